// File: doc/BRIEF.md
# Single-Wire Bus Master

This block is a memory-mapped master for a single open-drain data line. It runs one of two line disciplines: a slave-timed HDQ style, or a master-timed 1-Wire style. Software writes an eight-bit control word. When that word carries the start bit, it launches one operation: a break/reset with presence detect, a byte write, a byte read, or a one-bit transfer. The block pulls the line low through an output enable and samples the line through a synchronizer. It reports each completion through a sticky flag and an interrupt line.

Line timing is set by two parameter sets of clock counts, one for each discipline. Bits travel least significant first. In the 1-Wire discipline the master opens every read slot with a short low pulse and samples the line at a fixed point. In the HDQ discipline the master waits for the slave to pull the line low. It then judges the bit by whether the line is high again at a fixed point after that edge. If no edge comes within a window, the read ends with a timeout.

Top module: `swm_top`

## Requirements
- R1: A read at offset 0x00 returns the revision byte, with the major number in bits 7:4 and the minor number in bits 3:0.
- R2: A control write (offset 0x0C) with the start bit (bit 4) set but the clock-enable bit (bit 5) clear starts nothing: the line is never pulled, bit 4 reads back 0 and no flag is set.
- R3: A control write with bit 4 and bit 2 both set pulls the line low for exactly the reset-low count. It then sets flag bit 0 of the status register (offset 0x10). Control bit 3 reads 1 if a slave pulled the line low at the presence sample point, and 0 otherwise. Bits 4 and 2 read 0 afterwards.
- R4: With bit 4 set and bits 2 and 1 clear, the block sends the transmit byte (offset 0x04) least significant bit first. A 1 is a short low pulse (write-1 count) and a 0 is a long low pulse (write-0 count). The block then sets flag bit 2.
- R5: In the 1-Wire discipline (control bit 0 = 1), start with bit 1 set reads eight master-initiated slots, least significant bit first. The byte goes into the receive register (offset 0x08) and flag bit 1 is set.
- R6: In the HDQ discipline (control bit 0 = 0), a read waits for a slave low pulse for each bit. A pulse that has ended by the sample point is a 1, and a longer pulse is a 0. The byte goes into the receive register and flag bit 1 is set.
- R7: In an HDQ read, if no slave edge appears within the response window, flag bit 0 is set instead of flag bit 1, and the receive register keeps its value.
- R8: With control bit 7 set, exactly one bit moves. A write sends bit 0 of the transmit register. A read leaves the bit in receive bit 0, with bits 7:1 zero.
- R9: Flags accumulate across operations until the status register is read. That read returns them and clears them.
- R10: The interrupt output is high exactly when control bit 6 is 1 and at least one flag is set.
- R11: The line output enable is never asserted while the clock-enable bit is 0.
- R12: A control write while an operation is running has no effect on any control field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (clears the status flags at offset 0x10) |
| reg_addr_i | input | ADDR_W | Byte offset of the register |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i, combinational |
| irq_o | output | 1 | Interrupt request |
| line_i | input | 1 | Sampled level of the bus line |
| line_oe_o | output | 1 | 1 pulls the bus line low |

## Verification
The bench uses short timing sets: reset low of 30 or 40 clocks, bit slots of 12 or 16 clocks, write pulses of 2–3 versus 8–10 clocks, and response windows of 20 or 30 clocks. With these values, a full byte, a presence answer and an HDQ timeout each finish in a few hundred cycles, so every operation can run in both disciplines with random bytes. The revision is set to 2.5 so that both nibbles are distinct. Slave models decode pulse widths and answer reads and presence in both disciplines.

// File: rtl/swm_pkg.sv
package swm_pkg;
  localparam int unsigned TW    = 16;
  localparam int unsigned REG_W = 8;

  typedef struct packed {
    logic [TW-1:0] rst_low;
    logic [TW-1:0] pres_smp;
    logic [TW-1:0] rst_rec;
    logic [TW-1:0] slot;
    logic [TW-1:0] w1_low;
    logic [TW-1:0] w0_low;
    logic [TW-1:0] rd_low;
    logic [TW-1:0] rd_smp;
    logic [TW-1:0] resp_win;
  } swm_timing_t;

  typedef enum logic [1:0] {OP_BREAK, OP_WRITE, OP_READ} swm_op_e;
  typedef enum logic [2:0] {S_IDLE, S_RST, S_SLOT, S_HWAIT, S_HMEAS, S_HEND} swm_st_e;

  localparam logic [4:0] A_REV  = 5'h00;
  localparam logic [4:0] A_TX   = 5'h04;
  localparam logic [4:0] A_RX   = 5'h08;
  localparam logic [4:0] A_CTRL = 5'h0C;
  localparam logic [4:0] A_FLAG = 5'h10;

  localparam int unsigned B_SINGLE = 7;
  localparam int unsigned B_IE     = 6;
  localparam int unsigned B_CLKEN  = 5;
  localparam int unsigned B_GO     = 4;
  localparam int unsigned B_PRES   = 3;
  localparam int unsigned B_INIT   = 2;
  localparam int unsigned B_DIR    = 1;
  localparam int unsigned B_MODE   = 0;

  localparam int unsigned F_TX  = 2;
  localparam int unsigned F_RX  = 1;
  localparam int unsigned F_TMO = 0;

  // defaults sized for a 100 MHz clock
  localparam swm_timing_t SWM_HDQ_DEF = '{
    rst_low: 16'd19000, pres_smp: 16'd2000, rst_rec: 16'd4000,
    slot: 16'd19000, w1_low: 16'd4000, w0_low: 16'd10000,
    rd_low: 16'd100, rd_smp: 16'd6500, resp_win: 16'd32000};
  localparam swm_timing_t SWM_OW_DEF = '{
    rst_low: 16'd48000, pres_smp: 16'd7000, rst_rec: 16'd48000,
    slot: 16'd6500, w1_low: 16'd600, w0_low: 16'd6000,
    rd_low: 16'd600, rd_smp: 16'd1300, resp_win: 16'd6500};
endpackage

// File: rtl/swm_regs.sv
module swm_regs
  import swm_pkg::*;
#(
  parameter int unsigned ADDR_W    = 5,
  parameter logic [3:0]  REV_MAJOR = 4'd1,
  parameter logic [3:0]  REV_MINOR = 4'd0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              irq_o,
  output logic              clken_o,
  output logic              start_o,
  output swm_op_e           op_o,
  output logic              single_o,
  output logic              mode_o,
  output logic [REG_W-1:0]  tx_o,
  input  logic              busy_i,
  input  logic              tx_done_i,
  input  logic              rx_done_i,
  input  logic              tmo_i,
  input  logic              pres_i,
  input  logic [REG_W-1:0]  rx_i
);
  logic [REG_W-1:0] tx_q, rx_q;
  logic single_q, ie_q, clken_q, init_q, dir_q, mode_q;
  logic [2:0] flags_q, flag_set;
  logic sel_tx, sel_ctrl, sel_flag, ctrl_wr, flag_clr, any_done;
  logic unused_wbit;

  assign sel_tx   = addr_i == ADDR_W'(A_TX);
  assign sel_ctrl = addr_i == ADDR_W'(A_CTRL);
  assign sel_flag = addr_i == ADDR_W'(A_FLAG);
  assign ctrl_wr  = wr_i && sel_ctrl && !busy_i;
  assign flag_clr = rd_i && sel_flag;
  assign any_done = tx_done_i | rx_done_i | tmo_i;
  assign unused_wbit = wdata_i[B_PRES];

  assign start_o  = ctrl_wr && wdata_i[B_GO] && wdata_i[B_CLKEN];
  assign op_o     = wdata_i[B_INIT] ? OP_BREAK : (wdata_i[B_DIR] ? OP_READ : OP_WRITE);
  assign single_o = wdata_i[B_SINGLE];
  assign mode_o   = wdata_i[B_MODE];
  assign tx_o     = tx_q;
  assign clken_o  = clken_q;

  assign flag_set = {tx_done_i, rx_done_i, tmo_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= '0; rx_q <= '0; flags_q <= '0;
      single_q <= 1'b0; ie_q <= 1'b0; clken_q <= 1'b0;
      init_q <= 1'b0; dir_q <= 1'b0; mode_q <= 1'b0;
    end else begin
      if (wr_i && sel_tx) tx_q <= wdata_i;
      if (rx_done_i) rx_q <= rx_i;
      flags_q <= (flag_clr ? 3'b000 : flags_q) | flag_set;
      if (any_done) init_q <= 1'b0;
      if (ctrl_wr) begin
        single_q <= wdata_i[B_SINGLE];
        ie_q     <= wdata_i[B_IE];
        clken_q  <= wdata_i[B_CLKEN];
        init_q   <= wdata_i[B_INIT];
        dir_q    <= wdata_i[B_DIR];
        mode_q   <= wdata_i[B_MODE];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_W'(A_REV):  rdata_o = {REV_MAJOR, REV_MINOR};
      ADDR_W'(A_TX):   rdata_o = tx_q;
      ADDR_W'(A_RX):   rdata_o = rx_q;
      ADDR_W'(A_CTRL): rdata_o = {single_q, ie_q, clken_q, busy_i, pres_i, init_q, dir_q, mode_q};
      ADDR_W'(A_FLAG): rdata_o = {{(REG_W-3){1'b0}}, flags_q};
      default:         rdata_o = '0;
    endcase
  end

  assign irq_o = ie_q && (flags_q != 3'b000);

  // R2
  go_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_ctrl && !busy_i && wdata_i[B_GO] && !wdata_i[B_CLKEN]) |=> !busy_i);

  // R9
  flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr && !any_done) |=> (rdata_o == '0 || !sel_flag) && !irq_o);
endmodule

// File: rtl/swm_engine.sv
module swm_engine
  import swm_pkg::*;
#(
  parameter swm_timing_t HDQ_T  = SWM_HDQ_DEF,
  parameter swm_timing_t OW_T   = SWM_OW_DEF,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  swm_op_e           op_i,
  input  logic              single_i,
  input  logic              mode_i,
  input  logic [BYTE_W-1:0] tx_i,
  input  logic              line_i,
  output logic              busy_o,
  output logic              line_oe_o,
  output logic              tx_done_o,
  output logic              rx_done_o,
  output logic              tmo_o,
  output logic              pres_o,
  output logic [BYTE_W-1:0] rx_o
);
  localparam int unsigned IDX_W = $clog2(BYTE_W);
  localparam int unsigned CW    = TW + 1;

  swm_st_e st_q;
  swm_op_e op_q;
  logic [CW-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic single_q, mode_q, pres_q;
  logic [BYTE_W-1:0] tx_sh, rx_sh;
  swm_timing_t tm;
  logic [TW-1:0] low_len;
  logic [CW-1:0] rst_smp, rst_end, slot_end, win_end;
  logic last_bit;

  assign tm       = mode_q ? OW_T : HDQ_T;
  assign rst_smp  = CW'(tm.rst_low) + CW'(tm.pres_smp);
  assign rst_end  = CW'(tm.rst_low) + CW'(tm.rst_rec) - CW'(1);
  assign slot_end = CW'(tm.slot) - CW'(1);
  assign win_end  = CW'(tm.resp_win) - CW'(1);
  assign last_bit = single_q || (idx_q == IDX_W'(BYTE_W - 1));

  always_comb begin
    if (op_q == OP_READ) low_len = tm.rd_low;
    else if (tx_sh[0])   low_len = tm.w1_low;
    else                 low_len = tm.w0_low;
  end

  always_comb begin
    unique case (st_q)
      S_RST:   line_oe_o = cnt_q < CW'(tm.rst_low);
      S_SLOT:  line_oe_o = cnt_q < CW'(low_len);
      default: line_oe_o = 1'b0;
    endcase
  end

  assign busy_o = st_q != S_IDLE;
  assign pres_o = pres_q;
  assign rx_o   = single_q ? {{(BYTE_W-1){1'b0}}, rx_sh[BYTE_W-1]} : rx_sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE; op_q <= OP_WRITE; cnt_q <= '0; idx_q <= '0;
      single_q <= 1'b0; mode_q <= 1'b0; pres_q <= 1'b0;
      tx_sh <= '0; rx_sh <= '0;
      tx_done_o <= 1'b0; rx_done_o <= 1'b0; tmo_o <= 1'b0;
    end else begin
      tx_done_o <= 1'b0;
      rx_done_o <= 1'b0;
      tmo_o     <= 1'b0;
      unique case (st_q)
        S_IDLE: if (start_i) begin
          op_q <= op_i; single_q <= single_i; mode_q <= mode_i;
          tx_sh <= tx_i; rx_sh <= '0; cnt_q <= '0; idx_q <= '0;
          unique case (op_i)
            OP_BREAK: st_q <= S_RST;
            OP_WRITE: st_q <= S_SLOT;
            default:  st_q <= mode_i ? S_SLOT : S_HWAIT;
          endcase
        end
        S_RST: begin
          cnt_q <= cnt_q + CW'(1);
          if (cnt_q == rst_smp) pres_q <= ~line_i;
          if (cnt_q == rst_end) begin
            st_q  <= S_IDLE;
            tmo_o <= 1'b1;
          end
        end
        S_SLOT: begin
          cnt_q <= cnt_q + CW'(1);
          if (op_q == OP_READ && cnt_q == CW'(tm.rd_smp))
            rx_sh <= {line_i, rx_sh[BYTE_W-1:1]};
          if (cnt_q == slot_end) begin
            if (last_bit) begin
              st_q <= S_IDLE;
              if (op_q == OP_READ) rx_done_o <= 1'b1;
              else                 tx_done_o <= 1'b1;
            end else begin
              idx_q <= idx_q + IDX_W'(1);
              cnt_q <= '0;
              tx_sh <= tx_sh >> 1;
            end
          end
        end
        S_HWAIT: begin
          if (!line_i) begin
            st_q <= S_HMEAS; cnt_q <= '0;
          end else if (cnt_q == win_end) begin
            st_q <= S_IDLE; tmo_o <= 1'b1;
          end else cnt_q <= cnt_q + CW'(1);
        end
        S_HMEAS: begin
          cnt_q <= cnt_q + CW'(1);
          if (cnt_q == CW'(tm.rd_smp)) begin
            rx_sh <= {line_i, rx_sh[BYTE_W-1:1]};
            st_q  <= S_HEND;
            cnt_q <= '0;
          end
        end
        S_HEND: begin
          if (line_i) begin
            cnt_q <= '0;
            if (last_bit) begin
              st_q <= S_IDLE; rx_done_o <= 1'b1;
            end else begin
              st_q <= S_HWAIT; idx_q <= idx_q + IDX_W'(1);
            end
          end else if (cnt_q == win_end) begin
            st_q <= S_IDLE; tmo_o <= 1'b1;
          end else cnt_q <= cnt_q + CW'(1);
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  // R3, R4, R5, R7
  one_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $onehot({tx_done_o, rx_done_o, tmo_o}));

  // R12
  start_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o);

  // R11
  oe_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_oe_o |-> busy_o);
endmodule

// File: rtl/swm_top.sv
module swm_top
  import swm_pkg::*;
#(
  parameter int unsigned ADDR_W    = 5,
  parameter logic [3:0]  REV_MAJOR = 4'd1,
  parameter logic [3:0]  REV_MINOR = 4'd0,
  parameter int unsigned SYNC_N    = 2,
  parameter swm_timing_t HDQ_T     = SWM_HDQ_DEF,
  parameter swm_timing_t OW_T      = SWM_OW_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  output logic              irq_o,
  input  logic              line_i,
  output logic              line_oe_o
);
  logic [SYNC_N-1:0] sync_q;
  logic line_s, clken, start, single, mode, busy, tx_done, rx_done, tmo, pres;
  swm_op_e op;
  logic [REG_W-1:0] tx_byte, rx_byte;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_N-2:0], line_i};
  end
  assign line_s = sync_q[SYNC_N-1];

  swm_regs #(.ADDR_W(ADDR_W), .REV_MAJOR(REV_MAJOR), .REV_MINOR(REV_MINOR)) u_regs (
    .clk_i, .rst_ni,
    .wr_i(reg_wr_i), .rd_i(reg_rd_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o), .irq_o,
    .clken_o(clken), .start_o(start), .op_o(op), .single_o(single),
    .mode_o(mode), .tx_o(tx_byte), .busy_i(busy), .tx_done_i(tx_done),
    .rx_done_i(rx_done), .tmo_i(tmo), .pres_i(pres), .rx_i(rx_byte)
  );

  swm_engine #(.HDQ_T(HDQ_T), .OW_T(OW_T), .BYTE_W(REG_W)) u_engine (
    .clk_i, .rst_ni,
    .start_i(start), .op_i(op), .single_i(single), .mode_i(mode),
    .tx_i(tx_byte), .line_i(line_s), .busy_o(busy), .line_oe_o,
    .tx_done_o(tx_done), .rx_done_o(rx_done), .tmo_o(tmo),
    .pres_o(pres), .rx_o(rx_byte)
  );

  // R11
  idle_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clken |-> !line_oe_o);
endmodule

// File: tb/swm_top_bench.sv
module swm_top_bench;
  import swm_pkg::*;

  localparam swm_timing_t TB_HDQ = '{
    rst_low: 16'd40, pres_smp: 16'd8, rst_rec: 16'd24, slot: 16'd16,
    w1_low: 16'd3, w0_low: 16'd10, rd_low: 16'd2, rd_smp: 16'd6, resp_win: 16'd30};
  localparam swm_timing_t TB_OW = '{
    rst_low: 16'd30, pres_smp: 16'd8, rst_rec: 16'd20, slot: 16'd12,
    w1_low: 16'd2, w0_low: 16'd8, rd_low: 16'd2, rd_smp: 16'd6, resp_win: 16'd20};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr = 1'b0, rd = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic irq, oe, line;
  logic slave_t = 1'b0;
  logic pres_en = 1'b0;
  logic rd_mode = 1'b0;
  logic [7:0] rd_byte = '0;

  // monitor / slave model state
  int oe_len = 0, oe_cycles = 0, last_rst_len = 0, cap_total = 0;
  int hold_cnt = 0, pres_dly = 0;
  logic [2:0] rd_idx = '0;
  logic oe_prev = 1'b0;
  logic cap_hist [256];

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  assign line = ~(oe | slave_t | (hold_cnt != 0));

  swm_top #(.ADDR_W(5), .REV_MAJOR(4'h2), .REV_MINOR(4'h5), .SYNC_N(2),
            .HDQ_T(TB_HDQ), .OW_T(TB_OW)) u_swm_top (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_o(irq), .line_i(line), .line_oe_o(oe));

  always @(negedge clk) begin
    if (oe) begin
      oe_len <= oe_len + 1;
      oe_cycles <= oe_cycles + 1;
      if (!oe_prev && rd_mode) begin
        if (!rd_byte[rd_idx]) hold_cnt <= 10;
        rd_idx <= rd_idx + 3'd1;
      end
    end else begin
      if (oe_prev) begin
        if (oe_len >= 25) begin
          last_rst_len <= oe_len;
          if (pres_en) pres_dly <= 2;
        end else if (!rd_mode) begin
          cap_hist[cap_total % 256] <= (oe_len <= 5);
          cap_total <= cap_total + 1;
        end
      end
      oe_len <= 0;
    end
    if (!rd_mode) rd_idx <= '0;
    if (pres_dly != 0) begin
      pres_dly <= pres_dly - 1;
      if (pres_dly == 1) hold_cnt <= 12;
    end else if (hold_cnt != 0 && !(oe && !oe_prev && rd_mode)) hold_cnt <= hold_cnt - 1;
    oe_prev <= oe;
  end

  function automatic logic [7:0] ctrl_val(input logic single, ie, clken, go, init, dir, mode);
    return {single, ie, clken, go, 1'b0, init, dir, mode};
  endfunction

  function automatic logic [7:0] single_rx(input logic b);
    return {7'b0, b};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic reg_read(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic wait_irq(input string req);
    int n = 0;
    while (!irq && n < 3000) begin @(negedge clk); n++; end
    chk(req, irq, 1);
  endtask

  task automatic wait_idle(input string req);
    logic [7:0] c;
    int n = 0;
    reg_read(A_CTRL, c);
    while (c[B_GO] && n < 3000) begin reg_read(A_CTRL, c); n++; end
    chk(req, c[B_GO], 0);
  endtask

  task automatic hdq_send(input logic [7:0] d, input int nbits);
    repeat (4) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      slave_t = 1'b1;
      repeat (d[i] ? 3 : 12) @(negedge clk);
      slave_t = 1'b0;
      repeat (6) @(negedge clk);
    end
  endtask

  function automatic logic [7:0] cap_byte(input int start);
    logic [7:0] b;
    for (int i = 0; i < 8; i++) b[i] = cap_hist[(start + i) % 256];
    return b;
  endfunction

  task automatic do_write(input logic mode, input logic [7:0] d, input string req);
    logic [7:0] v;
    int s;
    s = cap_total;
    reg_write(A_TX, d);
    reg_write(A_CTRL, ctrl_val(0, 1, 1, 1, 0, 0, mode));
    wait_irq(req);
    repeat (2) @(negedge clk);
    chk({req, " bits"}, cap_total - s, 8);
    chk({req, " byte"}, cap_byte(s), d);
    reg_read(A_FLAG, v);
    chk({req, " flag"}, v, 8'h04);
  endtask

  task automatic do_read(input logic mode, input logic [7:0] d, input string req);
    logic [7:0] v;
    if (mode) begin
      rd_byte = d; rd_mode = 1'b1;
      reg_write(A_CTRL, ctrl_val(0, 1, 1, 1, 0, 1, 1));
      wait_irq(req);
      rd_mode = 1'b0;
    end else begin
      reg_write(A_CTRL, ctrl_val(0, 1, 1, 1, 0, 1, 0));
      hdq_send(d, 8);
      wait_irq(req);
    end
    reg_read(A_RX, v);
    chk({req, " data"}, v, d);
    reg_read(A_FLAG, v);
    chk({req, " flag"}, v, 8'h02);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    logic [7:0] v, d;
    int base;
    void'($urandom(32'h5EED_0017));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // reset state
    reg_read(A_CTRL, v);  chk("reset ctrl", v, 8'h00);
    reg_read(A_FLAG, v);  chk("reset flags", v, 8'h00);
    chk("reset irq", irq, 0);
    chk("reset oe", oe, 0);
    // R1
    reg_read(A_REV, v);   chk("R1 revision", v, 8'h25);

    // R2 / R11: start without clock enable
    base = oe_cycles;
    reg_write(A_CTRL, ctrl_val(0, 1, 0, 1, 0, 0, 1));
    repeat (60) @(negedge clk);
    chk("R2 no line activity", oe_cycles - base, 0);
    reg_read(A_CTRL, v);  chk("R2 go reads 0", v[B_GO], 0);
    reg_read(A_FLAG, v);  chk("R2 no flag", v, 8'h00);
    chk("R11 line idle", oe_cycles - base, 0);

    reg_write(A_CTRL, ctrl_val(0, 1, 1, 0, 0, 0, 1));
    chk("R10 no flag no irq", irq, 0);

    // R3 break with presence, both disciplines
    for (int m = 1; m >= 0; m--) begin
      pres_en = 1'b1;
      reg_write(A_CTRL, ctrl_val(0, 1, 1, 1, 1, 0, m[0]));
      wait_irq("R3 break done");
      chk("R3 reset low width", last_rst_len, m ? 30 : 40);
      reg_read(A_CTRL, v);
      chk("R3 ctrl after break", v, ctrl_val(0, 1, 1, 0, 0, 0, m[0]) | 8'h08);
      reg_read(A_FLAG, v);  chk("R3 timeout flag", v, 8'h01);
      chk("R9 cleared irq", irq, 0);
      reg_read(A_FLAG, v);  chk("R9 read clears", v, 8'h00);
      pres_en = 1'b0;
      reg_write(A_CTRL, ctrl_val(0, 1, 1, 1, 1, 0, m[0]));
      wait_irq("R3 break no slave");
      reg_read(A_CTRL, v);
      chk("R3 no presence", v, ctrl_val(0, 1, 1, 0, 0, 0, m[0]));
      reg_read(A_FLAG, v);  chk("R3 flag no slave", v, 8'h01);
    end

    // R10 masking
    reg_write(A_TX, 8'hA5);
    reg_write(A_CTRL, ctrl_val(0, 0, 1, 1, 0, 0, 1));
    wait_idle("R10 op done");
    repeat (2) @(negedge clk);
    chk("R10 masked irq", irq, 0);
    reg_write(A_CTRL, ctrl_val(0, 1, 1, 0, 0, 0, 1));
    #1 chk("R10 unmasked irq", irq, 1);
    reg_read(A_FLAG, v);  chk("R10 flag", v, 8'h04);

    // directed and random bytes
    do_write(1, 8'h00, "R4 ow write 00");
    do_write(0, 8'hFF, "R4 hdq write ff");
    do_read(1, 8'h00, "R5 ow read 00");
    do_read(0, 8'hFF, "R6 hdq read ff");
    for (int i = 0; i < 6; i++) begin
      d = 8'($urandom);
      do_write(i[0], d, "R4 random write");
      d = 8'($urandom);
      do_read(1, d, "R5 random read");
      d = 8'($urandom);
      do_read(0, d, "R6 random read");
    end

    // R9 accumulation
    reg_write(A_TX, 8'h3C);
    reg_write(A_CTRL, ctrl_val(0, 1, 1, 1, 0, 0, 1));
    wait_irq("R9 first op");
    rd_byte = 8'h81; rd_mode = 1'b1;
    reg_write(A_CTRL, ctrl_val(0, 1, 1, 1, 0, 1, 1));
    wait_idle("R9 second op");
    rd_mode = 1'b0;
    reg_read(A_FLAG, v);  chk("R9 accumulated flags", v, 8'h06);
    reg_read(A_FLAG, v);  chk("R9 cleared after read", v, 8'h00);

    // R8 single bit
    base = cap_total;
    reg_write(A_TX, 8'h02);
    reg_write(A_CTRL, ctrl_val(1, 1, 1, 1, 0, 0, 1));
    wait_irq("R8 single write 0");
    repeat (2) @(negedge clk);
    chk("R8 one pulse", cap_total - base, 1);
    chk("R8 bit value 0", cap_hist[base % 256], 0);
    reg_read(A_FLAG, v);  chk("R8 tx flag", v, 8'h04);
    base = cap_total;
    reg_write(A_TX, 8'h01);
    reg_write(A_CTRL, ctrl_val(1, 1, 1, 1, 0, 0, 0));
    wait_irq("R8 single write 1");
    repeat (2) @(negedge clk);
    chk("R8 one pulse hdq", cap_total - base, 1);
    chk("R8 bit value 1", cap_hist[base % 256], 1);
    reg_read(A_FLAG, v);
    rd_byte = 8'hFF; rd_mode = 1'b1;
    reg_write(A_CTRL, ctrl_val(1, 1, 1, 1, 0, 1, 1));
    wait_irq("R8 single read ow");
    rd_mode = 1'b0;
    reg_read(A_RX, v);    chk("R8 single read ow data", v, single_rx(1'b1));
    reg_read(A_FLAG, v);
    reg_write(A_CTRL, ctrl_val(1, 1, 1, 1, 0, 1, 0));
    hdq_send(8'h01, 1);
    wait_irq("R8 single read hdq");
    reg_read(A_RX, v);    chk("R8 single read hdq data", v, single_rx(1'b1));
    reg_read(A_FLAG, v);  chk("R8 rx flag", v, 8'h02);

    // R7 HDQ timeout
    reg_write(A_CTRL, ctrl_val(0, 1, 1, 1, 0, 1, 0));
    wait_irq("R7 timeout done");
    reg_read(A_FLAG, v);  chk("R7 timeout flag only", v, 8'h01);
    reg_read(A_RX, v);    chk("R7 rx kept", v, single_rx(1'b1));

    // R12 control write mid-operation
    reg_write(A_TX, 8'h5A);
    reg_write(A_CTRL, ctrl_val(0, 1, 1, 1, 0, 0, 1));
    repeat (5) @(negedge clk);
    reg_write(A_CTRL, ctrl_val(1, 0, 0, 0, 0, 1, 0));
    wait_irq("R12 op done");
    reg_read(A_CTRL, v);  chk("R12 ctrl unchanged", v, ctrl_val(0, 1, 1, 0, 0, 0, 1));
    reg_read(A_FLAG, v);  chk("R12 write completed", v, 8'h04);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule